// File: doc/BRIEF.md
# Electronic Shutter Substrate Pulse Controller

This block sets the charge-storage time of an interline CCD sensor. It issues short substrate drain requests that empty the photosites. Every request falls inside a horizontal blanking interval. In variable-shutter mode a request is issued on each line from the start of the field up to a chosen line. The last request before the field readout line marks the start of exposure, so the exposure lasts the programmed number of lines. The block follows the line and blanking strobes of the timing generator. It drives one logic-level substrate request to an external high-voltage driver, plus a readout-gate request during the blanking of the readout line.

Three modes are available. Off keeps the substrate output quiet, so storage lasts a full field. Variable uses the programmed line count, where zero means no shutter. Drain empties the sensor on every line and suppresses readout, for test use. The mode and line count are captured only at field start, so one field never mixes two settings. With the default 310-line readout position and a 64 µs line, a count of 62 gives an exposure of about 1/250 s. The pulse delay and width are parameters in clock cycles, sized for a 1.5 to 1.8 µs pulse.

Top module: `sub_shutter_ctrl`

## Requirements
- R1: After reset, and until the first `field_start`, `sub_req` and `readout_req` stay low whatever the other inputs do.
- R2: `mode_sel` and `shutter_lines` are captured only in the cycle `field_start` is high; a change during a field has no effect until the next field start.
- R3: `sub_req` is high only while `hblank` is high; a pulse cut short by the end of blanking, or by a line or field strobe, stops at once and does not resume.
- R4: Counting the first clock edge that samples `hblank` high as edge 0, a pulse starts after edge `SUB_DELAY` and lasts `SUB_WIDTH` clock periods when blanking is long enough; at most one pulse per line.
- R5: In variable mode (`mode_sel` = 2'b01) with count S ≥ 1, a pulse is issued on every line L with L + S ≤ `RO_LINE` and on no other line, so the last pulse is on line `RO_LINE` − S.
- R6: In variable mode a count of 0, or a count greater than `RO_LINE`, gives no pulse in the field.
- R7: In off mode (2'b00), and for the unused code 2'b11, `sub_req` stays low for the whole field.
- R8: In drain mode (2'b10), a pulse is issued on every line outside the guard lines, and `readout_req` stays low.
- R9: In every mode no pulse is issued on line `RO_LINE` or line `RO_LINE`+1.
- R10: In off and variable modes, `readout_req` is high during the blanking of line `RO_LINE` and at no other time.
- R11: `field_start` sets the line index to 0 even when `line_start` is high in the same cycle; each later `line_start` adds one, and a new `field_start` restarts the numbering mid-field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| field_start | input | 1 | One-cycle field start strobe; also starts line 0 |
| line_start | input | 1 | One-cycle line start strobe |
| hblank | input | 1 | High during horizontal blanking |
| mode_sel | input | 2 | 00 off, 01 variable, 10 drain, 11 treated as off |
| shutter_lines | input | LINE_W | Exposure length in lines for variable mode |
| sub_req | output | 1 | Substrate drain request to the external driver |
| readout_req | output | 1 | Readout-gate request on the readout line |

## Verification
The field strobe and the line strobe fall in the same cycle at the start of every field. There the field reset of the line index must win over the increment, and the settings capture must take effect in that same cycle. The bench drives both strobes together on line 0. It then cuts a field short and starts a new one mid-count. In the new field the window of pulsed lines and the two quiet guard lines must line up with the restarted numbering and not with the old count. A mid-field settings change is also made, and the bench checks that only the next field picks it up.

// File: rtl/shut_pkg.sv
package shut_pkg;
   typedef enum logic [1:0] {
      SHUT_OFF   = 2'b00,
      SHUT_VAR   = 2'b01,
      SHUT_DRAIN = 2'b10,
      SHUT_RSVD  = 2'b11
   } shut_mode_e;

   typedef enum logic [1:0] {
      PS_IDLE = 2'b00,
      PS_WAIT = 2'b01,
      PS_ACT  = 2'b10
   } pulse_st_e;
endpackage

// File: rtl/shut_line_ctr.sv
module shut_line_ctr #(
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              field_start,
   input  logic              line_start,
   output logic [LINE_W-1:0] line_idx,
   output logic              field_valid
);
   localparam logic [LINE_W-1:0] LINE_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_idx    <= '0;
         field_valid <= 1'b0;
      end else if (field_start) begin
         line_idx    <= '0;
         field_valid <= 1'b1;
      end else if (line_start && line_idx != LINE_MAX) begin
         line_idx <= line_idx + 1'b1;
      end
   end
endmodule

// File: rtl/shut_setting_reg.sv
module shut_setting_reg import shut_pkg::*; #(
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              field_start,
   input  logic [1:0]        mode_in,
   input  logic [LINE_W-1:0] lines_in,
   output shut_mode_e        mode_q,
   output logic [LINE_W-1:0] lines_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= SHUT_OFF;
         lines_q <= '0;
      end else if (field_start) begin
         mode_q  <= shut_mode_e'(mode_in);
         lines_q <= lines_in;
      end
   end
endmodule

// File: rtl/shut_line_qual.sv
module shut_line_qual import shut_pkg::*; #(
   parameter int LINE_W  = 10,
   parameter int RO_LINE = 310
) (
   input  logic [LINE_W-1:0] line_idx,
   input  logic [LINE_W-1:0] lines_q,
   input  shut_mode_e        mode_q,
   input  logic              field_valid,
   output logic              pulse_ok,
   output logic              ro_ok
);
   localparam int SW = LINE_W + 1;
   localparam logic [LINE_W-1:0] RO_IDX    = LINE_W'(RO_LINE);
   localparam logic [LINE_W-1:0] GUARD_IDX = LINE_W'(RO_LINE + 1);
   localparam logic [SW-1:0]     RO_EXT    = SW'(RO_LINE);

   logic          guard;
   logic [SW-1:0] reach;
   logic          in_window;

   assign guard     = (line_idx == RO_IDX) || (line_idx == GUARD_IDX);
   assign reach     = {1'b0, line_idx} + {1'b0, lines_q};
   assign in_window = (lines_q != '0) && (reach <= RO_EXT);

   always_comb begin
      pulse_ok = 1'b0;
      unique case (mode_q)
         SHUT_VAR:   pulse_ok = in_window;
         SHUT_DRAIN: pulse_ok = 1'b1;
         default:    pulse_ok = 1'b0;
      endcase
      pulse_ok = pulse_ok && !guard && field_valid;
   end

   assign ro_ok = field_valid && (line_idx == RO_IDX) && (mode_q != SHUT_DRAIN);
endmodule

// File: rtl/shut_pulse_gen.sv
module shut_pulse_gen import shut_pkg::*; #(
   parameter int SUB_DELAY = 4,
   parameter int SUB_WIDTH = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hblank,
   input  logic clear,
   input  logic start_ok,
   output logic sub_o
);
   localparam int SPAN = (SUB_DELAY > SUB_WIDTH) ? SUB_DELAY : SUB_WIDTH;
   localparam int CW   = (SPAN < 2) ? 1 : $clog2(SPAN + 1);
   localparam logic [CW-1:0] WID_LAST = CW'(SUB_WIDTH - 1);

   pulse_st_e     state;
   pulse_st_e     first_st;
   logic [CW-1:0] first_cnt;
   logic [CW-1:0] cnt;
   logic          hb_d;
   logic          rise;

   generate
      if (SUB_DELAY == 0) begin : g_no_delay
         assign first_st  = PS_ACT;
         assign first_cnt = WID_LAST;
      end else begin : g_delay
         assign first_st  = PS_WAIT;
         assign first_cnt = CW'(SUB_DELAY - 1);
      end
   endgenerate

   assign rise = hblank && !hb_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PS_IDLE;
         cnt   <= '0;
         hb_d  <= 1'b0;
      end else begin
         hb_d <= hblank;
         if (!hblank || clear) begin
            state <= PS_IDLE;
            cnt   <= '0;
         end else begin
            unique case (state)
               PS_IDLE: if (rise && start_ok) begin
                  state <= first_st;
                  cnt   <= first_cnt;
               end
               PS_WAIT: if (cnt == '0) begin
                  state <= PS_ACT;
                  cnt   <= WID_LAST;
               end else begin
                  cnt <= cnt - 1'b1;
               end
               PS_ACT: if (cnt == '0) begin
                  state <= PS_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
               default: state <= PS_IDLE;
            endcase
         end
      end
   end

   assign sub_o = (state == PS_ACT) && hblank;
endmodule

// File: rtl/sub_shutter_ctrl.sv
module sub_shutter_ctrl import shut_pkg::*; #(
   parameter int LINE_W    = 10,
   parameter int RO_LINE   = 310,
   parameter int SUB_DELAY = 4,
   parameter int SUB_WIDTH = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              field_start,
   input  logic              line_start,
   input  logic              hblank,
   input  logic [1:0]        mode_sel,
   input  logic [LINE_W-1:0] shutter_lines,
   output logic              sub_req,
   output logic              readout_req
);
   localparam int LINE_TOP = (1 << LINE_W) - 1;

   generate
      if (LINE_W < 2) begin : g_bad_width
         $error("sub_shutter_ctrl: LINE_W must be at least 2");
      end
      if (RO_LINE + 2 > LINE_TOP) begin : g_bad_ro
         $error("sub_shutter_ctrl: RO_LINE+2 must fit below the line counter limit");
      end
      if (SUB_WIDTH < 1) begin : g_bad_pw
         $error("sub_shutter_ctrl: SUB_WIDTH must be at least 1");
      end
      if (SUB_DELAY < 0) begin : g_bad_dly
         $error("sub_shutter_ctrl: SUB_DELAY must not be negative");
      end
   endgenerate

   logic [LINE_W-1:0] line_idx;
   logic              field_valid;
   shut_mode_e        mode_q;
   logic [LINE_W-1:0] lines_q;
   logic              pulse_ok;
   logic              ro_ok;

   shut_line_ctr #(.LINE_W(LINE_W)) u_line (
      .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_start(line_start),
      .line_idx(line_idx), .field_valid(field_valid)
   );

   shut_setting_reg #(.LINE_W(LINE_W)) u_set (
      .clk(clk), .rst_n(rst_n), .field_start(field_start), .mode_in(mode_sel),
      .lines_in(shutter_lines), .mode_q(mode_q), .lines_q(lines_q)
   );

   shut_line_qual #(.LINE_W(LINE_W), .RO_LINE(RO_LINE)) u_qual (
      .line_idx(line_idx), .lines_q(lines_q), .mode_q(mode_q), .field_valid(field_valid),
      .pulse_ok(pulse_ok), .ro_ok(ro_ok)
   );

   shut_pulse_gen #(.SUB_DELAY(SUB_DELAY), .SUB_WIDTH(SUB_WIDTH)) u_pulse (
      .clk(clk), .rst_n(rst_n), .hblank(hblank), .clear(line_start || field_start),
      .start_ok(pulse_ok), .sub_o(sub_req)
   );

   assign readout_req = ro_ok && hblank;
endmodule

// File: rtl/sub_shutter_chk.sv
module sub_shutter_chk import shut_pkg::*; #(
   parameter int LINE_W    = 10,
   parameter int RO_LINE   = 310,
   parameter int SUB_WIDTH = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hblank,
   input logic              field_start,
   input logic              sub_req,
   input logic              readout_req,
   input logic [LINE_W-1:0] line_idx,
   input shut_mode_e        mode_q,
   input logic [LINE_W-1:0] lines_q,
   input logic              field_valid
);
   localparam int RW = $clog2(SUB_WIDTH + 1) + 1;
   localparam logic [RW-1:0] RUN_LIM = RW'(SUB_WIDTH);
   localparam logic [LINE_W:0] RO_EXT = (LINE_W+1)'(RO_LINE);

   logic [RW-1:0] run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_cnt <= '0;
      else if (sub_req) run_cnt <= run_cnt + 1'b1;
      else              run_cnt <= '0;
   end

   AST_NO_OUTPUT_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
      !field_valid |-> (!sub_req && !readout_req)); // R1
   AST_SETTING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !field_start |=> ($stable(lines_q) && $stable(mode_q))); // R2
   AST_SUB_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      sub_req |-> hblank); // R3
   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      sub_req |-> (run_cnt < RUN_LIM)); // R4
   AST_VAR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_req && mode_q == SHUT_VAR) |->
         (lines_q != '0 && ({1'b0, line_idx} + {1'b0, lines_q}) <= RO_EXT)); // R5
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == SHUT_OFF || mode_q == SHUT_RSVD) |-> !sub_req); // R7
   AST_DRAIN_NO_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == SHUT_DRAIN) |-> !readout_req); // R8
   AST_GUARD_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      sub_req |-> (line_idx != LINE_W'(RO_LINE) && line_idx != LINE_W'(RO_LINE + 1))); // R9
   AST_READOUT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      readout_req |-> (hblank && line_idx == LINE_W'(RO_LINE))); // R10
endmodule

bind sub_shutter_ctrl sub_shutter_chk #(
   .LINE_W(LINE_W), .RO_LINE(RO_LINE), .SUB_WIDTH(SUB_WIDTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hblank(hblank), .field_start(field_start),
   .sub_req(sub_req), .readout_req(readout_req), .line_idx(line_idx),
   .mode_q(mode_q), .lines_q(lines_q), .field_valid(field_valid)
);

// File: tb/tb_sub_shutter_ctrl.sv
module tb_sub_shutter_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int LW  = 5;
   localparam int RO  = 10;
   localparam int DLY = 3;
   localparam int WID = 6;
   localparam int ACT = 6;
   localparam int HB  = 12;
   localparam int NL  = RO + 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          field_start = 1'b0;
   logic          line_start = 1'b0;
   logic          hblank = 1'b0;
   logic [1:0]    mode_sel = 2'b00;
   logic [LW-1:0] shutter_lines = '0;
   logic          sub_req;
   logic          readout_req;

   int n_checks = 0;
   int n_fail   = 0;
   int pcnt   [0:31];
   int pfirst [0:31];
   bit ro_seen[0:31];
   bit bad_bl [0:31];
   int cur_line = 0;

   sub_shutter_ctrl #(.LINE_W(LW), .RO_LINE(RO), .SUB_DELAY(DLY), .SUB_WIDTH(WID)) dut (
      .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_start(line_start),
      .hblank(hblank), .mode_sel(mode_sel), .shutter_lines(shutter_lines),
      .sub_req(sub_req), .readout_req(readout_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
   end

   task automatic check_int(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(bit fs, bit ls, bit hb, int j);
      @(posedge clk);
      #1;
      field_start = fs;
      line_start  = ls;
      hblank      = hb;
      @(negedge clk);
      if (sub_req) begin
         if (!hblank) bad_bl[cur_line] = 1'b1;
         pcnt[cur_line]++;
         if (pfirst[cur_line] < 0) pfirst[cur_line] = j;
      end
      if (readout_req) ro_seen[cur_line] = 1'b1;
   endtask

   task automatic run_line(bit fs, int hb_len);
      step(fs, 1'b1, 1'b0, -1);
      for (int k = 0; k < ACT; k++) step(1'b0, 1'b0, 1'b0, -1);
      for (int j = 0; j < hb_len; j++) step(1'b0, 1'b0, 1'b1, j);
      step(1'b0, 1'b0, 1'b0, -1);
   endtask

   task automatic run_field(int nlines, int hb_len, bit with_fs,
                            int chg_line, logic [1:0] nm, int ns);
      for (int l = 0; l < 32; l++) begin
         pcnt[l] = 0; pfirst[l] = -1; ro_seen[l] = 1'b0; bad_bl[l] = 1'b0;
      end
      for (int l = 0; l < nlines; l++) begin
         if (l == chg_line) begin
            mode_sel = nm;
            shutter_lines = LW'(ns);
         end
         cur_line = l;
         run_line(with_fs && l == 0, hb_len);
      end
   endtask

   function automatic bit exp_pulse(int l, logic [1:0] m, int s, bit valid);
      if (!valid || l == RO || l == RO + 1) return 1'b0;
      case (m)
         2'b01:   return (s != 0) && (l + s <= RO);
         2'b10:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check_field(int nlines, int hb_len, logic [1:0] m, int s, bit valid,
                              string tag, string wtag);
      int full;
      full = (hb_len - 1 - DLY >= WID) ? WID : hb_len - 1 - DLY;
      for (int l = 0; l < nlines; l++) begin
         bit on;
         bit ro;
         on = exp_pulse(l, m, s, valid);
         ro = valid && (l == RO) && (m != 2'b10);
         if (l == RO || l == RO + 1)
            check_int("R9", $sformatf("guard line %0d pulse cycles", l), pcnt[l], 0);
         else if (on)
            check_int(wtag, $sformatf("line %0d pulse cycles", l), pcnt[l], full);
         else
            check_int(tag, $sformatf("line %0d pulse cycles", l), pcnt[l], 0);
         if (on)
            check_int("R4", $sformatf("line %0d pulse start", l), pfirst[l], DLY + 1);
         check_int("R3", $sformatf("line %0d pulse outside blanking", l), int'(bad_bl[l]), 0);
         check_int((m == 2'b10) ? "R8" : "R10", $sformatf("line %0d readout", l),
                   int'(ro_seen[l]), int'(ro));
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_int("R1", "sub_req in reset", int'(sub_req), 0);
      check_int("R1", "readout_req in reset", int'(readout_req), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      mode_sel = 2'b10;
      run_field(NL, HB, 1'b0, -1, 2'b00, 0);
      check_field(NL, HB, 2'b10, 0, 1'b0, "R1", "R1");
   endtask

   task automatic t_variable(int s, string tag);
      mode_sel = 2'b01;
      shutter_lines = LW'(s);
      run_field(NL, HB, 1'b1, -1, 2'b00, 0);
      check_field(NL, HB, 2'b01, s, 1'b1, tag, "R4");
   endtask

   task automatic t_off(logic [1:0] m);
      mode_sel = m;
      shutter_lines = LW'(4);
      run_field(NL, HB, 1'b1, -1, 2'b00, 0);
      check_field(NL, HB, m, 4, 1'b1, "R7", "R7");
   endtask

   task automatic t_drain(int hb_len, string wtag);
      mode_sel = 2'b10;
      run_field(NL, hb_len, 1'b1, -1, 2'b00, 0);
      check_field(NL, hb_len, 2'b10, 0, 1'b1, "R8", wtag);
   endtask

   task automatic t_latch();
      mode_sel = 2'b01;
      shutter_lines = LW'(5);
      run_field(NL, HB, 1'b1, 2, 2'b10, 1);
      check_field(NL, HB, 2'b01, 5, 1'b1, "R2", "R2");
      run_field(NL, HB, 1'b1, -1, 2'b00, 0);
      check_field(NL, HB, 2'b10, 1, 1'b1, "R2", "R2");
   endtask

   task automatic t_restart();
      mode_sel = 2'b01;
      shutter_lines = LW'(3);
      run_field(5, HB, 1'b1, -1, 2'b00, 0);
      check_field(5, HB, 2'b01, 3, 1'b1, "R11", "R11");
      run_field(NL, HB, 1'b1, -1, 2'b00, 0);
      check_field(NL, HB, 2'b01, 3, 1'b1, "R11", "R11");
   endtask

   initial begin
      t_reset();
      t_variable(4, "R5");
      t_variable(RO, "R5");
      t_variable(0, "R6");
      t_variable(RO + 1, "R6");
      t_off(2'b00);
      t_off(2'b11);
      t_drain(HB, "R8");
      t_latch();
      t_drain(DLY + 3, "R3");
      t_restart();
      summary();
   end
endmodule